// File: doc/BRIEF.md
# Lane Routing and Squelch Matrix

This block steers the data words of four unidirectional serial lanes, arranged as two pairs, onto four output lanes under one shared routing mode. Within each pair the even-numbered lane is the primary and the odd-numbered lane is the secondary (lane 0 = pair A primary, lane 1 = pair A secondary, lane 2 = pair B primary, lane 3 = pair B secondary). Three routing modes are supported. Multicast copies each primary input onto both outputs of its pair. Direct connect passes every input straight through to the output of the same index. Cross connect moves each primary input onto the secondary output of the pair and silences the primary output.

Any output that has no source in the current mode is squelched. So is any output whose selected source reports electrical idle, and any output for which either that output lane or its source lane is disabled. A squelched output raises its idle flag and carries a fixed idle word instead of toggling data. A change of mode is registered. The single cycle in which the new mode is first seen squelches every output, so that no mixture of old and new routes can appear. A status vector marks the inputs that the applied mode discards.

The lanes are continuous streams and have no back-pressure: a data word is consumed on every clock, and an output word counts as valid exactly when its idle flag is low. The number of pairs and the word width are parameters.

Top module: `lrm_route_matrix`

## Requirements
- R1: While reset is asserted, and after it, every output idle flag reads 1, every output word equals IDLE_WORD, and the ignored vector reads 0. The applied mode after reset is direct connect.
- R2: The mode select is decoded as 00 = multicast, 01 = direct connect and 10 = cross connect. Code 11 behaves exactly like direct connect.
- R3: In multicast, input lane 2g drives both output 2g and output 2g+1.
- R4: In direct connect, input lane i drives output lane i.
- R5: In cross connect, input lane 2g drives output 2g+1, and output 2g is squelched.
- R6: An output whose selected source has its idle flag set is squelched: its idle flag reads 1 and its word equals IDLE_WORD.
- R7: An output is squelched whenever its own enable bit or the enable bit of its selected source is 0, in every mode.
- R8: Outputs are registered. The values present at a rising edge appear on the outputs just after that edge.
- R9: At a rising edge where the decoded mode differs from the mode applied at the previous edge, every output is squelched. The new mode routes from the following edge on.
- R10: The ignored vector has bit 2g+1 set for every pair while the applied mode is multicast or cross connect, and reads all zeros in direct connect. It follows the mode applied at the last edge.
- R11: All pairs switch together under the single mode select and follow the same routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Routing mode code |
| lane_data_i | input | 2*GROUPS*DATA_W | Input words; lane i at bits [i*DATA_W +: DATA_W] |
| lane_idle_i | input | 2*GROUPS | Per-lane electrical-idle report from the receivers |
| lane_en_i | input | 2*GROUPS | Per-lane enable; 0 = lane powered down |
| lane_data_o | output | 2*GROUPS*DATA_W | Output words, same packing as the input |
| lane_idle_o | output | 2*GROUPS | Per-output squelch flag |
| ignored_o | output | 2*GROUPS | Input lanes discarded by the applied mode |

## Verification
The bench targets the edge at which the mode changes. A design that routed with the new mode at once would leak old-route or new-route data in that cycle, and one that held the squelch for a second cycle would drop a valid word. It drives code 11 to catch a decoder that treats the unused code as cross connect or multicast. It also exercises idle and disable on a source lane feeding two outputs in multicast, where a design that looked only at the output lane's own flags would keep toggling a copied output. Pair B is checked on every cycle as well, which exposes any pair that fails to track the shared mode or indexes its source from the wrong pair.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  typedef enum logic [1:0] {
    MODE_MCAST  = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_CROSS  = 2'b10
  } route_mode_e;

  // Unused code 11 falls back to straight-through routing.
  function automatic route_mode_e decode_mode(input logic [1:0] sel);
    route_mode_e m;
    case (sel)
      2'b00:   m = MODE_MCAST;
      2'b10:   m = MODE_CROSS;
      default: m = MODE_DIRECT;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lrm_mode_ctl.sv
module lrm_mode_ctl
  import lrm_pkg::*;
#(
  parameter int GROUPS = 2,
  localparam int LANES = 2 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  output route_mode_e       mode_now,
  output route_mode_e       mode_applied,
  output logic              switching,
  output logic [LANES-1:0]  ignored
);

  assign mode_now = decode_mode(mode_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_applied <= MODE_DIRECT;
    else        mode_applied <= mode_now;
  end

  assign switching = (mode_now != mode_applied);

  for (genvar g = 0; g < GROUPS; g++) begin : g_ign
    assign ignored[2*g]   = 1'b0;
    assign ignored[2*g+1] = (mode_applied != MODE_DIRECT);
  end

  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switching |=> (mode_applied == $past(mode_now)));

endmodule

// File: rtl/lrm_src_sel.sv
module lrm_src_sel
  import lrm_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int LANE_IDX = 0,
  localparam int IDXW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int PRIMARY = LANE_IDX - (LANE_IDX % 2)
) (
  input  route_mode_e      mode,
  output logic [IDXW-1:0]  src_idx,
  output logic             src_used
);

  localparam logic [IDXW-1:0] SELF_IDX = IDXW'(LANE_IDX);
  localparam logic [IDXW-1:0] PRIM_IDX = IDXW'(PRIMARY);
  localparam bit              IS_PRIM  = (LANE_IDX % 2) == 0;

  always_comb begin
    src_idx  = SELF_IDX;
    src_used = 1'b1;
    case (mode)
      MODE_MCAST: src_idx = PRIM_IDX;
      MODE_CROSS: begin
        src_idx  = PRIM_IDX;
        src_used = !IS_PRIM;
      end
      default: src_idx = SELF_IDX;
    endcase
  end

endmodule

// File: rtl/lrm_lane_out.sv
module lrm_lane_out #(
  parameter int              DATA_W    = 10,
  parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out,
  output logic              idle_out
);

  always_ff @(posedge clk) begin
    if (!rst_n || !pass) begin
      word_out <= IDLE_WORD;
      idle_out <= 1'b1;
    end else begin
      word_out <= word_in;
      idle_out <= 1'b0;
    end
  end

endmodule

// File: rtl/lrm_route_matrix.sv
module lrm_route_matrix
  import lrm_pkg::*;
#(
  parameter int                DATA_W    = 10,
  parameter int                GROUPS    = 2,
  parameter logic [DATA_W-1:0] IDLE_WORD = '0,
  localparam int               LANES     = 2 * GROUPS,
  localparam int               IDXW      = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_sel,
  input  logic [LANES*DATA_W-1:0] lane_data_i,
  input  logic [LANES-1:0]        lane_idle_i,
  input  logic [LANES-1:0]        lane_en_i,
  output logic [LANES*DATA_W-1:0] lane_data_o,
  output logic [LANES-1:0]        lane_idle_o,
  output logic [LANES-1:0]        ignored_o
);

  route_mode_e mode_now;
  route_mode_e mode_applied;
  logic        switching;

  lrm_mode_ctl #(.GROUPS(GROUPS)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .mode_now     (mode_now),
    .mode_applied (mode_applied),
    .switching    (switching),
    .ignored      (ignored_o)
  );

  logic [DATA_W-1:0] in_word [LANES];
  logic [IDXW-1:0]   src_idx [LANES];
  logic [LANES-1:0]  src_used;
  logic [LANES-1:0]  pass;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign in_word[i] = lane_data_i[i*DATA_W +: DATA_W];

    lrm_src_sel #(.LANES(LANES), .LANE_IDX(i)) u_sel (
      .mode     (mode_now),
      .src_idx  (src_idx[i]),
      .src_used (src_used[i])
    );

    assign pass[i] = !switching && src_used[i] && lane_en_i[i]
                   && lane_en_i[src_idx[i]] && !lane_idle_i[src_idx[i]];

    lrm_lane_out #(.DATA_W(DATA_W), .IDLE_WORD(IDLE_WORD)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pass     (pass[i]),
      .word_in  (in_word[src_idx[i]]),
      .word_out (lane_data_o[i*DATA_W +: DATA_W]),
      .idle_out (lane_idle_o[i])
    );

    // R7
    lane_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en_i[i] |=> lane_idle_o[i]);

    // R6
    src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_idle_i[src_idx[i]] |=> lane_idle_o[i]);

    // R6
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_idle_o[i] |-> (lane_data_o[i*DATA_W +: DATA_W] == IDLE_WORD));

    // R4
    direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now == MODE_DIRECT && mode_applied == MODE_DIRECT
       && lane_en_i[i] && !lane_idle_i[i])
      |=> (!lane_idle_o[i]
           && lane_data_o[i*DATA_W +: DATA_W] == $past(lane_data_i[i*DATA_W +: DATA_W])));
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_pair
    // R5
    cross_prim_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now == MODE_CROSS) |=> lane_idle_o[2*g]);
  end

  // R9
  switch_squelch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switching |=> (&lane_idle_o));

endmodule

// File: tb/lrm_route_matrix_bench.sv
module lrm_route_matrix_bench;

  localparam int W = 10;
  localparam int G = 2;
  localparam int L = 2 * G;
  localparam logic [W-1:0] IW = 10'h2A5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     mode_sel = 2'b01;
  logic [L*W-1:0] lane_data_i = '0;
  logic [L-1:0]   lane_idle_i = '0;
  logic [L-1:0]   lane_en_i = '1;
  logic [L*W-1:0] lane_data_o;
  logic [L-1:0]   lane_idle_o;
  logic [L-1:0]   ignored_o;

  lrm_route_matrix #(.DATA_W(W), .GROUPS(G), .IDLE_WORD(IW)) u_lrm_route_matrix (
    .clk, .rst_n, .mode_sel, .lane_data_i, .lane_idle_i, .lane_en_i,
    .lane_data_o, .lane_idle_o, .ignored_o
  );

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int           applied_mode;
  logic         exp_idle [L];
  logic [W-1:0] exp_data [L];
  string        exp_tag  [L];
  logic [L-1:0] exp_ign;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic int dec(logic [1:0] s);
    if (s == 2'b00) return 0;
    if (s == 2'b10) return 2;
    return 1;
  endfunction

  // -1 means the output has no source in this mode
  function automatic int src_of(int m, int o);
    int prim = o - (o % 2);
    if (m == 0) return prim;
    if (m == 2) return (o % 2 == 1) ? prim : -1;
    return o;
  endfunction

  task automatic predict();
    int nm = dec(mode_sel);
    bit sw = (nm != applied_mode);
    for (int o = 0; o < L; o++) begin
      int s = src_of(nm, o);
      exp_idle[o] = 1'b1;
      exp_data[o] = IW;
      if (sw) exp_tag[o] = "R9";
      else if (s < 0) exp_tag[o] = "R5";
      else if (!lane_en_i[o] || !lane_en_i[s]) exp_tag[o] = "R7";
      else if (lane_idle_i[s]) exp_tag[o] = "R6";
      else begin
        exp_idle[o] = 1'b0;
        exp_data[o] = lane_data_i[s*W +: W];
        if (mode_sel == 2'b11) exp_tag[o] = "R2 R8";
        else if (nm == 0) exp_tag[o] = "R3 R8";
        else if (nm == 1) exp_tag[o] = "R4 R8";
        else exp_tag[o] = "R5 R8";
      end
      if (o >= 2) exp_tag[o] = {exp_tag[o], " R11"};
    end
    for (int g = 0; g < G; g++) begin
      exp_ign[2*g]   = 1'b0;
      exp_ign[2*g+1] = (nm != 1);
    end
    applied_mode = nm;
  endtask

  task automatic compare_all();
    for (int o = 0; o < L; o++) begin
      chk(lane_idle_o[o] == exp_idle[o], exp_tag[o], $sformatf("idle lane %0d", o),
          lane_idle_o[o], exp_idle[o]);
      chk(lane_data_o[o*W +: W] == exp_data[o], exp_tag[o], $sformatf("data lane %0d", o),
          lane_data_o[o*W +: W], exp_data[o]);
    end
    chk(ignored_o == exp_ign, "R10", "ignored", ignored_o, exp_ign);
  endtask

  task automatic stim(int n);
    for (int i = 0; i < L; i++) lane_data_i[i*W +: W] = W'($urandom);
    lane_idle_i = '0;
    lane_en_i   = '1;
    if (n < 8) mode_sel = 2'b01;
    else if (n < 16) mode_sel = 2'b00;
    else if (n < 24) mode_sel = 2'b10;
    else if (n < 32) mode_sel = 2'b11;
    else if (n < 40) begin
      mode_sel = 2'b01;
      lane_idle_i = L'(1) << (n % L);
    end else if (n < 48) begin
      mode_sel = 2'b00;
      lane_en_i = ~(L'(1) << (n % L));
    end else if (n < 56) begin
      mode_sel = 2'b10;
      lane_idle_i = (n % 2 == 0) ? L'(1) : L'(4);
    end else if (n < 64) begin
      mode_sel = 2'b00;
      lane_idle_i = (n % 2 == 0) ? L'(1) : L'(0);
    end else begin
      if ($urandom_range(5) == 0) mode_sel = 2'($urandom);
      for (int i = 0; i < L; i++) begin
        lane_idle_i[i] = ($urandom_range(4) == 0);
        lane_en_i[i]   = ($urandom_range(7) != 0);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    applied_mode = 1;
    repeat (3) @(negedge clk);
    // R1: state held under reset
    for (int o = 0; o < L; o++) begin
      chk(lane_idle_o[o] == 1'b1, "R1", $sformatf("reset idle lane %0d", o), lane_idle_o[o], 1);
      chk(lane_data_o[o*W +: W] == IW, "R1", $sformatf("reset data lane %0d", o),
          lane_data_o[o*W +: W], IW);
    end
    chk(ignored_o == '0, "R1", "reset ignored", ignored_o, 0);
    rst_n = 1'b1;
    stim(0);
    predict();
    for (int n = 1; n < 600; n++) begin
      @(negedge clk);
      compare_all();
      stim(n);
      predict();
    end
    @(negedge clk);
    compare_all();
    finish_run();
  end

  initial begin
    #(4 * 5000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

endmodule